// File: doc/BRIEF.md
# Two-Class GPIO Tunnel Channel

This block carries two classes of slow GPIO signals over a frame link. Every frame has a fixed GPIO payload. Low-latency inputs each own one bit of that payload and travel in every frame. Normal-latency inputs share a smaller pool of bits. The pool carries one slice of them per frame, so a full refresh of that class takes several frames.

On each frame strobe the transmit half captures a coherent snapshot of the inputs. It adds a slice index and presents the frame one cycle later with a one-cycle valid pulse. The receive half takes a valid frame and copies the low-latency bits to its outputs. It writes the slice into the matching positions of the normal-latency output register. Frames whose slice index is out of range are dropped. The surrounding link (serialization, training, coding, other fields) carries the payload and is not part of this block.

Top module: `gpio_tunnel`

## Requirements
- R1: After reset, tx_valid is 0, ll_out and nl_out are all zero, and the first frame sent carries slice index 0.
- R2: In the cycle after a cycle with tx_strobe high, tx_valid is 1 and tx_frame bits [LL_CNT-1:0] equal ll_in as sampled in the strobe cycle, with ll_in[i] at bit i.
- R3: In that frame, bit LL_CNT+k equals nl_in[s*NL_BITS+k] sampled in the strobe cycle, where s is the frame's slice index and k runs from 0 to NL_BITS-1. A position with s*NL_BITS+k >= NL_CNT is sent as 0.
- R4: The slice index occupies the top IDX_W bits of tx_frame, where IDX_W = ceil(log2 SLICES) (minimum 1) and SLICES = ceil(NL_CNT/NL_BITS). It starts at 0, rises by one per strobe and wraps to 0 after SLICES-1.
- R5: In a cycle that does not follow a strobe cycle, tx_valid is 0 and tx_frame keeps its previous value.
- R6: In the cycle after rx_valid is high with an index below SLICES, ll_out equals bits [LL_CNT-1:0] of rx_frame.
- R7: The same frame updates nl_out[s*NL_BITS+k] with rx_frame bit LL_CNT+k for each position below NL_CNT. All other nl_out bits hold, and padded positions have no effect.
- R8: A valid frame whose index is SLICES or more is discarded: ll_out and nl_out hold.
- R9: While rx_valid is low, ll_out and nl_out hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_strobe | input | 1 | Frame strobe: capture inputs and emit one frame |
| ll_in | input | LL_CNT | Low-latency GPIO inputs |
| nl_in | input | NL_CNT | Normal-latency GPIO inputs |
| tx_valid | output | 1 | One-cycle pulse marking a new tx_frame |
| tx_frame | output | FRAME_W | Transmit payload: {index, slice, low-latency bits} |
| rx_valid | input | 1 | Received payload is valid this cycle |
| rx_frame | input | FRAME_W | Received payload, same layout as tx_frame |
| ll_out | output | LL_CNT | Low-latency GPIO outputs |
| nl_out | output | NL_CNT | Normal-latency GPIO outputs |

## Verification
A transmit frame is due one cycle after its strobe cycle. A receive output change is due one cycle after the cycle in which rx_valid was high. The bench drives inputs on the falling edge and samples 1 ns later. It pushes each expected frame into a queue when it raises the strobe and pops the queue only when tx_valid is seen. Its receive model is updated only after it compares the outputs against the model's state from before the current frame. Each frame is therefore checked exactly one sampling point after the one where it was presented, and every other sampling point checks that the outputs held.

// File: rtl/gpio_tunnel_pkg.sv
package gpio_tunnel_pkg;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/gt_rst_sync.sv
module gt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sn = stage_q[1];

endmodule

// File: rtl/gt_slice_ctr.sv
module gt_slice_ctr #(
  parameter int SLICES = 3,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv) begin
      if (idx_q == IDX_W'(SLICES - 1)) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/gt_tx_pack.sv
module gt_tx_pack #(
  parameter int LL_CNT  = 4,
  parameter int NL_CNT  = 10,
  parameter int NL_BITS = 4,
  parameter int SLICES  = 3,
  parameter int IDX_W   = 2,
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LL_CNT-1:0]  ll_in,
  input  logic [NL_CNT-1:0]  nl_in,
  output logic               valid,
  output logic [FRAME_W-1:0] frame
);

  localparam int PAD_W = SLICES * NL_BITS - NL_CNT;

  logic [SLICES*NL_BITS-1:0] padded;
  logic [NL_BITS-1:0]        slice_d;
  logic [FRAME_W-1:0]        frame_d;
  logic [FRAME_W-1:0]        frame_q;
  logic                      valid_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign padded = {{PAD_W{1'b0}}, nl_in};
    end else begin : g_nopad
      assign padded = nl_in;
    end
  endgenerate

  always_comb begin
    slice_d = '0;
    for (int s = 0; s < SLICES; s++) begin
      if (idx == IDX_W'(s)) begin
        slice_d = padded[s*NL_BITS +: NL_BITS];
      end
    end
  end

  assign frame_d = {idx, slice_d, ll_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      frame_q <= '0;
    end else begin
      valid_q <= strobe;
      if (strobe) begin
        frame_q <= frame_d;
      end
    end
  end

  assign valid = valid_q;
  assign frame = frame_q;

endmodule

// File: rtl/gt_rx_unpack.sv
module gt_rx_unpack #(
  parameter int LL_CNT  = 4,
  parameter int NL_CNT  = 10,
  parameter int NL_BITS = 4,
  parameter int SLICES  = 3,
  parameter int IDX_W   = 2,
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [FRAME_W-1:0] rx_frame,
  output logic [LL_CNT-1:0]  ll_out,
  output logic [NL_CNT-1:0]  nl_out
);

  logic [IDX_W-1:0]   idx;
  logic [NL_BITS-1:0] slice;
  logic               accept;
  logic [LL_CNT-1:0]  ll_q;
  logic [LL_CNT-1:0]  ll_d;
  logic [NL_CNT-1:0]  nl_q;
  logic [NL_CNT-1:0]  nl_d;

  assign idx    = rx_frame[FRAME_W-1 -: IDX_W];
  assign slice  = rx_frame[LL_CNT +: NL_BITS];
  assign accept = rx_valid && ({1'b0, idx} < (IDX_W + 1)'(SLICES));
  assign ll_d   = accept ? rx_frame[LL_CNT-1:0] : ll_q;

  generate
    for (genvar p = 0; p < NL_CNT; p++) begin : g_nl
      localparam int S_OF = p / NL_BITS;
      localparam int K_OF = p % NL_BITS;
      assign nl_d[p] = (accept && (idx == IDX_W'(S_OF))) ? slice[K_OF] : nl_q[p];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ll_q <= '0;
      nl_q <= '0;
    end else begin
      ll_q <= ll_d;
      nl_q <= nl_d;
    end
  end

  assign ll_out = ll_q;
  assign nl_out = nl_q;

endmodule

// File: rtl/gpio_tunnel.sv
module gpio_tunnel
  import gpio_tunnel_pkg::*;
#(
  parameter int LL_CNT  = 4,
  parameter int NL_CNT  = 10,
  parameter int NL_BITS = 4,
  localparam int SLICES  = ceil_div(NL_CNT, NL_BITS),
  localparam int IDX_W   = idx_width(SLICES),
  localparam int FRAME_W = LL_CNT + NL_BITS + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_strobe,
  input  logic [LL_CNT-1:0]  ll_in,
  input  logic [NL_CNT-1:0]  nl_in,
  output logic               tx_valid,
  output logic [FRAME_W-1:0] tx_frame,
  input  logic               rx_valid,
  input  logic [FRAME_W-1:0] rx_frame,
  output logic [LL_CNT-1:0]  ll_out,
  output logic [NL_CNT-1:0]  nl_out
);

  logic             rst_sn;
  logic [IDX_W-1:0] slice_idx;

  gt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  gt_slice_ctr #(
    .SLICES (SLICES),
    .IDX_W  (IDX_W)
  ) u_ctr (
    .clk   (clk),
    .rst_n (rst_sn),
    .adv   (tx_strobe),
    .idx   (slice_idx)
  );

  gt_tx_pack #(
    .LL_CNT  (LL_CNT),
    .NL_CNT  (NL_CNT),
    .NL_BITS (NL_BITS),
    .SLICES  (SLICES),
    .IDX_W   (IDX_W),
    .FRAME_W (FRAME_W)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_sn),
    .strobe (tx_strobe),
    .idx    (slice_idx),
    .ll_in  (ll_in),
    .nl_in  (nl_in),
    .valid  (tx_valid),
    .frame  (tx_frame)
  );

  gt_rx_unpack #(
    .LL_CNT  (LL_CNT),
    .NL_CNT  (NL_CNT),
    .NL_BITS (NL_BITS),
    .SLICES  (SLICES),
    .IDX_W   (IDX_W),
    .FRAME_W (FRAME_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_sn),
    .rx_valid (rx_valid),
    .rx_frame (rx_frame),
    .ll_out   (ll_out),
    .nl_out   (nl_out)
  );

endmodule

// File: rtl/gpio_tunnel_chk.sv
module gpio_tunnel_chk #(
  parameter int LL_CNT  = 4,
  parameter int NL_CNT  = 10,
  parameter int SLICES  = 3,
  parameter int IDX_W   = 2,
  parameter int FRAME_W = 10
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               tx_strobe,
  input logic [LL_CNT-1:0]  ll_in,
  input logic               tx_valid,
  input logic [FRAME_W-1:0] tx_frame,
  input logic               rx_valid,
  input logic [FRAME_W-1:0] rx_frame,
  input logic [LL_CNT-1:0]  ll_out,
  input logic [NL_CNT-1:0]  nl_out
);

  logic past_ok;
  logic rx_idx_ok;
  logic tx_idx_ok;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  assign rx_idx_ok = {1'b0, rx_frame[FRAME_W-1 -: IDX_W]} < (IDX_W + 1)'(SLICES);
  assign tx_idx_ok = {1'b0, tx_frame[FRAME_W-1 -: IDX_W]} < (IDX_W + 1)'(SLICES);

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && $past(tx_strobe) |-> tx_valid); // R2

  AST_TX_LL_FIELD: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && $past(tx_strobe) |-> tx_frame[LL_CNT-1:0] == $past(ll_in)); // R2

  AST_TX_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_valid |-> tx_idx_ok); // R4

  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && !$past(tx_strobe) |-> !tx_valid && $stable(tx_frame)); // R5

  AST_RX_LL_LOAD: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && $past(rx_valid) && $past(rx_idx_ok) |-> ll_out == $past(rx_frame[LL_CNT-1:0])); // R6

  AST_RX_DISCARD: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && $past(rx_valid) && !$past(rx_idx_ok) |-> $stable(ll_out) && $stable(nl_out)); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && !$past(rx_valid) |-> $stable(ll_out) && $stable(nl_out)); // R9

endmodule

bind gpio_tunnel gpio_tunnel_chk #(
  .LL_CNT  (LL_CNT),
  .NL_CNT  (NL_CNT),
  .SLICES  (SLICES),
  .IDX_W   (IDX_W),
  .FRAME_W (FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .tx_strobe (tx_strobe),
  .ll_in     (ll_in),
  .tx_valid  (tx_valid),
  .tx_frame  (tx_frame),
  .rx_valid  (rx_valid),
  .rx_frame  (rx_frame),
  .ll_out    (ll_out),
  .nl_out    (nl_out)
);

// File: tb/sim_gpio_tunnel.sv
`timescale 1ns/1ps
module sim_gpio_tunnel;

  localparam int LL  = 4;
  localparam int NL  = 10;
  localparam int NB  = 4;
  localparam int NS  = 3;
  localparam int IW  = 2;
  localparam int FW  = LL + NB + IW;

  logic          clk;
  logic          rst_n;
  logic          tx_strobe;
  logic [LL-1:0] ll_in;
  logic [NL-1:0] nl_in;
  logic          tx_valid;
  logic [FW-1:0] tx_frame;
  logic          rx_valid;
  logic [FW-1:0] rx_frame;
  logic [LL-1:0] ll_out;
  logic [NL-1:0] nl_out;

  logic          inj_on;
  logic          inj_v;
  logic [FW-1:0] inj_f;

  int n_cmp;
  int n_bad;
  bit done;
  bit started;

  logic [FW-1:0] exp_q[$];
  int            exp_idx;
  logic [LL-1:0] m_ll;
  logic [NL-1:0] m_nl;
  int            last_kind;

  assign rx_valid = inj_on ? inj_v : tx_valid;
  assign rx_frame = inj_on ? inj_f : tx_frame;

  gpio_tunnel #(.LL_CNT(LL), .NL_CNT(NL), .NL_BITS(NB)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_strobe (tx_strobe),
    .ll_in     (ll_in),
    .nl_in     (nl_in),
    .tx_valid  (tx_valid),
    .tx_frame  (tx_frame),
    .rx_valid  (rx_valid),
    .rx_frame  (rx_frame),
    .ll_out    (ll_out),
    .nl_out    (nl_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [LL-1:0] l, input logic [NL-1:0] n);
    logic [FW-1:0] f;
    f[LL-1:0] = l;
    for (int k = 0; k < NB; k++) begin
      int pos;
      pos = exp_idx * NB + k;
      f[LL+k] = (pos < NL) ? n[pos] : 1'b0;
    end
    f[FW-1 -: IW] = IW'(exp_idx);
    exp_q.push_back(f);
    exp_idx = (exp_idx == NS - 1) ? 0 : exp_idx + 1;
    ll_in = l;
    nl_in = n;
    tx_strobe = 1'b1;
    @(negedge clk);
    tx_strobe = 1'b0;
    ll_in = ~l;
    nl_in = ~n;
  endtask

  task automatic inject(input logic [FW-1:0] f);
    inj_on = 1'b1;
    inj_v = 1'b1;
    inj_f = f;
    @(negedge clk);
    inj_v = 1'b0;
    inj_f = ~f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: sample 1 ns after each falling edge.
  always @(negedge clk) begin
    #1;
    if (started) begin
      if (tx_valid) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected tx_valid", 32'd1, 32'd0);
        end else begin
          logic [FW-1:0] e;
          e = exp_q.pop_front();
          check("R2 ll field", 32'(tx_frame[LL-1:0]), 32'(e[LL-1:0]));
          check("R3 nl slice field", 32'(tx_frame[LL +: NB]), 32'(e[LL +: NB]));
          check("R4 slice index", 32'(tx_frame[FW-1 -: IW]), 32'(e[FW-1 -: IW]));
        end
      end
      case (last_kind)
        1: begin
          check("R6 ll_out load", 32'(ll_out), 32'(m_ll));
          check("R7 nl_out slice", 32'(nl_out), 32'(m_nl));
        end
        2: begin
          check("R8 ll_out discard", 32'(ll_out), 32'(m_ll));
          check("R8 nl_out discard", 32'(nl_out), 32'(m_nl));
        end
        default: begin
          check("R9 ll_out hold", 32'(ll_out), 32'(m_ll));
          check("R9 nl_out hold", 32'(nl_out), 32'(m_nl));
        end
      endcase
      if (rx_valid) begin
        int ix;
        ix = int'(rx_frame[FW-1 -: IW]);
        if (ix < NS) begin
          m_ll = rx_frame[LL-1:0];
          for (int k = 0; k < NB; k++) begin
            if (ix * NB + k < NL) m_nl[ix*NB+k] = rx_frame[LL+k];
          end
          last_kind = 1;
        end else begin
          last_kind = 2;
        end
      end else begin
        last_kind = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0; started = 0;
    exp_idx = 0; m_ll = '0; m_nl = '0; last_kind = 0;
    rst_n = 1'b0; tx_strobe = 1'b0; ll_in = '0; nl_in = '0;
    inj_on = 1'b0; inj_v = 1'b0; inj_f = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    check("R1 tx_valid", 32'(tx_valid), 32'd0);
    check("R1 ll_out", 32'(ll_out), 32'd0);
    check("R1 nl_out", 32'(nl_out), 32'd0);
    started = 1;
    // First frame carries index 0 (R1), then a full rotation back to back
    send(4'hA, 10'h3A5);
    send(4'h5, 10'h3A5);
    send(4'hF, 10'h3A5);
    idle(2);
    // Gapped strobes with new patterns, wrap twice (R4)
    send(4'h1, 10'h0FF);
    idle(3);
    send(4'h2, 10'h300);
    idle(1);
    send(4'h8, 10'h155);
    send(4'h0, 10'h2AA);
    send(4'hC, 10'h3FF);
    send(4'h3, 10'h000);
    idle(5);
    // Discarded frame with out-of-range index 3 (R8)
    inject({2'd3, 4'hF, 4'h6});
    idle(2);
    // Last slice with padded positions set: only nl_out[9:8] may change (R7)
    inject({2'd2, 4'b1110, 4'h9});
    idle(2);
    inject({2'd1, 4'b0110, 4'h4});
    idle(3);
    inj_on = 1'b0;
    send(4'h7, 10'h1C3);
    idle(4);
    if (exp_q.size() != 0) check("R2 frames missing", 32'(exp_q.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule